// File: doc/BRIEF.md
# Banked Core Register File

This block holds the architectural registers of a 32-bit processor core: thirteen general-purpose registers, a stack pointer slot backed by two physical registers, a link register, a program counter, and a small set of status, mask and control registers. Two combinational read ports and one write port, each addressed by a 4-bit register number, serve the integer datapath. A separate port addresses the status, mask and control registers through a 3-bit selector.

The current exception number comes in from the exception logic. A nonzero number means handler mode, and zero means thread mode. Handler mode is always privileged. Thread mode is privileged while CONTROL bit 0 is clear. The block enforces write permissions from these two conditions.

After reset a small loader reads two words from memory through a request/response port. The first word becomes the main stack pointer and the second becomes the program counter. Only then does the block raise `ready`.

Top module: `core_regfile`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ready` is low. In that first cycle the link register (index 14) reads 0xFFFFFFFF. The combined status view reads 0x01000000. PRIMASK, FAULTMASK, BASEPRI and CONTROL all read 0.
- R2: After reset the loader goes through idle, stack fetch, PC fetch and ready, in that order. `mem_req` stays high with address 0x00000000 until a cycle with `mem_rvalid`, and then stays high with address 0x00000004 until the next `mem_rvalid`. `ready` rises one cycle after the second response and stays high until reset. The main stack pointer takes the first word and the PC takes the second word.
- R3: While `ready` is low, writes on both write ports have no effect and never raise `fault`.
- R4: Reads are combinational. A write to indices 0–12 takes effect at the next rising edge. A read of a register in the same cycle as a write to it returns the old value.
- R5: Index 13 selects the process stack pointer only when the exception number is 0 and CONTROL bit 1 is 1. Otherwise it selects the main stack pointer, for both reads and writes.
- R6: Index 15 always reads with bit 0 equal to 0. A write to index 15 stores the data with bit 0 cleared.
- R7: A write to selector 4 (PRIMASK, bit 0), 5 (FAULTMASK, bit 0), 6 (BASEPRI, bits 7:0) or 7 (CONTROL, bits 1:0) made while unprivileged is dropped, and `fault` is high for the following cycle. Privileged means the exception number is nonzero or CONTROL bit 0 is 0.
- R8: Selector 1 reads the exception number. Selector 2 reads the constant 0x01000000. Selector 3 reads the OR of selectors 0, 1 and 2. Writes to selectors 1, 2 and 3 are dropped and raise no fault.
- R9: Selector 0 holds flag bits 31:27 and reads 0 in all its other bits. Fields of selectors 4–7 outside their listed bits read 0.
- R10: Indices 0–15 and selector 0 are writable at either privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_num | input | 9 | Active exception number, 0 in thread mode |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Core register write enable |
| wr_idx | input | 4 | Core register write number |
| wr_data | input | 32 | Core register write data |
| sys_wr_en | input | 1 | Status/mask/control write enable |
| sys_wr_sel | input | 3 | Status/mask/control write selector |
| sys_wr_data | input | 32 | Status/mask/control write data |
| sys_rd_sel | input | 3 | Status/mask/control read selector |
| sys_rd_data | output | 32 | Status/mask/control read data |
| mem_req | output | 1 | Loader read request |
| mem_addr | output | 32 | Loader read address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| ready | output | 1 | Reset load complete |
| fault | output | 1 | One-cycle pulse after a denied write |

## Verification
A read and a write can hit the same register in the same cycle. A bank-switching write to CONTROL can also coincide with a read of index 13. The bench provokes both on purpose. A behavioural model in the bench keeps the pre-edge state until the clock edge. Every combinational output is compared against that model after each input change, so a read that sees the new value is caught. Denied writes are checked the same way, with the model predicting the `fault` pulse for the following cycle.

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter logic [31:0] SP_VEC = 32'h0000_0000,
  parameter logic [31:0] PC_VEC = 32'h0000_0004,
  parameter int          EXC_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_W-1:0] exc_num,
  input  logic [3:0]       rd_a_idx,
  output logic [31:0]      rd_a_data,
  input  logic [3:0]       rd_b_idx,
  output logic [31:0]      rd_b_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             sys_wr_en,
  input  logic [2:0]       sys_wr_sel,
  input  logic [31:0]      sys_wr_data,
  input  logic [2:0]       sys_rd_sel,
  output logic [31:0]      sys_rd_data,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             ready,
  output logic             fault
);
  localparam int NGPR = 13;
  localparam logic [31:0] EXEC_VIEW = 32'h0100_0000;

  typedef enum logic [1:0] {LD_IDLE, LD_SP, LD_PC, LD_READY} ld_t;

  ld_t         st;
  logic [31:0] gpr [NGPR];
  logic [31:0] msp, psp, lr, pc;
  logic [4:0]  flags;
  logic        primask, faultmask;
  logic [7:0]  basepri;
  logic [1:0]  control;
  logic        fault_q;

  logic handler, priv, use_psp, wr_ok, sys_ok, denied;
  logic [31:0] app_view, int_view;

  assign handler  = |exc_num;
  assign priv     = handler | ~control[0];
  assign use_psp  = ~handler & control[1];
  assign ready    = (st == LD_READY);
  assign wr_ok    = wr_en & ready;
  assign sys_ok   = sys_wr_en & ready;
  assign denied   = sys_ok & sys_wr_sel[2] & ~priv;
  assign mem_req  = (st == LD_SP) | (st == LD_PC);
  assign mem_addr = (st == LD_PC) ? PC_VEC : SP_VEC;
  assign fault    = fault_q;
  assign app_view = {flags, 27'b0};
  assign int_view = 32'(exc_num);

  function automatic logic [31:0] core_rd(input logic [3:0] idx);
    case (idx)
      4'd13:   core_rd = use_psp ? psp : msp;
      4'd14:   core_rd = lr;
      4'd15:   core_rd = pc;
      default: core_rd = gpr[idx];
    endcase
  endfunction

  assign rd_a_data = core_rd(rd_a_idx);
  assign rd_b_data = core_rd(rd_b_idx);

  always_comb begin
    case (sys_rd_sel)
      3'd0:    sys_rd_data = app_view;
      3'd1:    sys_rd_data = int_view;
      3'd2:    sys_rd_data = EXEC_VIEW;
      3'd3:    sys_rd_data = app_view | int_view | EXEC_VIEW;
      3'd4:    sys_rd_data = {31'b0, primask};
      3'd5:    sys_rd_data = {31'b0, faultmask};
      3'd6:    sys_rd_data = {24'b0, basepri};
      default: sys_rd_data = {30'b0, control};
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok && wr_idx < 4'(NGPR)) gpr[wr_idx] <= wr_data;
    if (wr_ok && wr_idx == 4'd13 && use_psp) psp <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= LD_IDLE;
      msp       <= '0;
      lr        <= 32'hFFFF_FFFF;
      pc        <= '0;
      flags     <= '0;
      primask   <= 1'b0;
      faultmask <= 1'b0;
      basepri   <= '0;
      control   <= '0;
      fault_q   <= 1'b0;
    end else begin
      fault_q <= denied;
      case (st)
        LD_IDLE: st <= LD_SP;
        LD_SP: if (mem_rvalid) begin
          msp <= mem_rdata;
          st  <= LD_PC;
        end
        LD_PC: if (mem_rvalid) begin
          pc <= {mem_rdata[31:1], 1'b0};
          st <= LD_READY;
        end
        default: st <= LD_READY;
      endcase
      if (wr_ok) begin
        case (wr_idx)
          4'd13:   if (!use_psp) msp <= wr_data;
          4'd14:   lr <= wr_data;
          4'd15:   pc <= {wr_data[31:1], 1'b0};
          default: ;
        endcase
      end
      if (sys_ok) begin
        case (sys_wr_sel)
          3'd0: flags <= sys_wr_data[31:27];
          3'd4: if (priv) primask   <= sys_wr_data[0];
          3'd5: if (priv) faultmask <= sys_wr_data[0];
          3'd6: if (priv) basepri   <= sys_wr_data[7:0];
          3'd7: if (priv) control   <= sys_wr_data[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/core_regfile_chk.sv
module core_regfile_chk #(parameter int EXC_W = 9) (
  input logic             clk,
  input logic             rst_n,
  input logic [EXC_W-1:0] exc_num,
  input logic [3:0]       rd_a_idx,
  input logic [31:0]      rd_a_data,
  input logic             sys_wr_en,
  input logic [2:0]       sys_wr_sel,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic             ready,
  input logic             fault
);
  assert_req_only_loading_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);
  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> mem_req);
  assert_pc_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_a_idx == 4'd15) |-> !rd_a_data[0]);
  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(sys_wr_en && ready && sys_wr_sel[2] && exc_num == '0));
  assert_quiet_loading_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !fault);
endmodule

bind core_regfile core_regfile_chk #(.EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_num(exc_num), .rd_a_idx(rd_a_idx),
  .rd_a_data(rd_a_data), .sys_wr_en(sys_wr_en), .sys_wr_sel(sys_wr_sel),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .ready(ready), .fault(fault)
);

// File: tb/core_regfile_tb.sv
module core_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0]  exc_num = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sys_wr_data = '0, sys_rd_data;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        wr_en = 1'b0, sys_wr_en = 1'b0, mem_req, mem_rvalid = 1'b0, ready, fault;
  logic [2:0]  sys_wr_sel = '0, sys_rd_sel = '0;

  core_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .exc_num(exc_num),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sys_wr_en(sys_wr_en), .sys_wr_sel(sys_wr_sel), .sys_wr_data(sys_wr_data),
    .sys_rd_sel(sys_rd_sel), .sys_rd_data(sys_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ready(ready), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  string tag = "R1";

  logic [31:0] m_gpr [13];
  logic [31:0] m_msp, m_psp, m_lr, m_pc;
  logic [4:0]  m_flags;
  logic        m_pm, m_fm, m_fault;
  logic [7:0]  m_bp;
  logic [1:0]  m_ctl;
  int          m_ld;

  function automatic logic [31:0] ref_rd(input logic [3:0] idx);
    if (idx == 4'd13) return (exc_num == 0 && m_ctl[1]) ? m_psp : m_msp;
    if (idx == 4'd14) return m_lr;
    if (idx == 4'd15) return m_pc;
    return m_gpr[idx];
  endfunction

  function automatic logic [31:0] ref_sys(input logic [2:0] sel);
    logic [31:0] a = {m_flags, 27'b0};
    logic [31:0] i = {23'b0, exc_num};
    case (sel)
      3'd0: return a;
      3'd1: return i;
      3'd2: return 32'h0100_0000;
      3'd3: return a | i | 32'h0100_0000;
      3'd4: return {31'b0, m_pm};
      3'd5: return {31'b0, m_fm};
      3'd6: return {24'b0, m_bp};
      default: return {30'b0, m_ctl};
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    if ($isunknown(exp)) return;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (m_gpr[k]) m_gpr[k] = 'x;
    m_msp = 'x; m_psp = 'x; m_pc = 'x; m_lr = 32'hFFFF_FFFF;
    m_flags = '0; m_pm = 0; m_fm = 0; m_bp = '0; m_ctl = '0; m_fault = 0; m_ld = 0;
  endtask

  task automatic model_edge();
    bit rdy = (m_ld == 3);
    bit hnd = (exc_num != 0);
    bit prv = hnd || !m_ctl[0];
    logic [1:0] ctl_old = m_ctl;
    m_fault = 0;
    if (m_ld == 0) m_ld = 1;
    else if (m_ld == 1 && mem_rvalid) begin m_msp = mem_rdata; m_ld = 2; end
    else if (m_ld == 2 && mem_rvalid) begin m_pc = {mem_rdata[31:1], 1'b0}; m_ld = 3; end
    if (rdy && wr_en) begin
      if (wr_idx < 13) m_gpr[wr_idx] = wr_data;
      else if (wr_idx == 13) begin
        if (!hnd && ctl_old[1]) m_psp = wr_data; else m_msp = wr_data;
      end
      else if (wr_idx == 14) m_lr = wr_data;
      else m_pc = {wr_data[31:1], 1'b0};
    end
    if (rdy && sys_wr_en) begin
      if (sys_wr_sel == 0) m_flags = sys_wr_data[31:27];
      else if (sys_wr_sel >= 4) begin
        if (!prv) m_fault = 1;
        else if (sys_wr_sel == 4) m_pm = sys_wr_data[0];
        else if (sys_wr_sel == 5) m_fm = sys_wr_data[0];
        else if (sys_wr_sel == 6) m_bp = sys_wr_data[7:0];
        else m_ctl = sys_wr_data[1:0];
      end
    end
  endtask

  task automatic tick();
    #1;
    chk("rd_a", rd_a_data, ref_rd(rd_a_idx));
    chk("rd_b", rd_b_data, ref_rd(rd_b_idx));
    chk("sys_rd", sys_rd_data, ref_sys(sys_rd_sel));
    chk("ready", {31'b0, ready}, {31'b0, m_ld == 3});
    chk("mem_req", {31'b0, mem_req}, {31'b0, m_ld == 1 || m_ld == 2});
    if (m_ld == 1 || m_ld == 2) chk("mem_addr", mem_addr, (m_ld == 1) ? 32'h0 : 32'h4);
    chk("fault", {31'b0, fault}, {31'b0, m_fault});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 0; sys_wr_en = 0; mem_rvalid = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d;
  endtask

  task automatic swr(input logic [2:0] s, input logic [31:0] d);
    sys_wr_en = 1; sys_wr_sel = s; sys_wr_data = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; rd_a_idx = 14; rd_b_idx = 14; sys_rd_sel = 3; tick();
    sys_rd_sel = 7; tick();
    tag = "R3"; sys_rd_sel = 4; wr(0, 32'h5); swr(4, 1); tick();
    wr(14, 32'h1234); swr(7, 3); tick();
    tag = "R2"; mem_rvalid = 1; mem_rdata = 32'h2000_1000; tick();
    rd_a_idx = 13; tick();
    mem_rvalid = 1; mem_rdata = 32'h0000_0101; tick();
    tag = "R2"; rd_a_idx = 15; rd_b_idx = 13; tick();
    tag = "R3"; rd_a_idx = 14; rd_b_idx = 0; sys_rd_sel = 7; tick();

    tag = "R4"; rd_a_idx = 3; rd_b_idx = 3; wr(3, 32'hA5A5_0003); tick();
    wr(3, 32'h0000_1234); tick();
    tick();
    for (int r = 0; r < 13; r++) begin
      rd_a_idx = 4'(r); wr(4'(r), 32'h1111_1111 * r + r); tick();
    end
    for (int r = 0; r < 13; r++) begin
      rd_a_idx = 4'(r); rd_b_idx = 4'(12 - r); tick();
    end

    tag = "R5"; rd_a_idx = 13; rd_b_idx = 13; wr(13, 32'h2000_0800); tick();
    swr(7, 2); sys_rd_sel = 7; tick();
    wr(13, 32'h3000_0000); tick();
    tick();
    exc_num = 5; tick();
    wr(13, 32'h2000_0700); tick();
    tick();
    exc_num = 0; tick();

    tag = "R6"; rd_a_idx = 15; wr(15, 32'h0000_0203); tick();
    tick();
    wr(15, 32'hFFFF_FFFF); tick();
    tick();

    tag = "R7"; swr(7, 3); tick();
    sys_rd_sel = 4; swr(4, 1); tick();
    sys_rd_sel = 6; swr(6, 32'h40); tick();
    sys_rd_sel = 5; swr(5, 1); tick();
    sys_rd_sel = 7; swr(7, 0); tick();
    tick();
    tag = "R10"; rd_a_idx = 10; wr(10, 32'hCAFE_000A); sys_rd_sel = 0; swr(0, 32'hFFFF_FFFF); tick();
    sys_rd_sel = 3; tick();
    rd_a_idx = 14; wr(14, 32'h0BAD_F00D); tick();
    tick();

    tag = "R7"; exc_num = 3; sys_rd_sel = 4; swr(4, 1); tick();
    sys_rd_sel = 6; swr(6, 32'hFFFF_FF80); tick();
    sys_rd_sel = 7; swr(7, 0); tick();
    tag = "R8"; sys_rd_sel = 1; swr(1, 32'hFFFF_FFFF); tick();
    sys_rd_sel = 3; swr(3, 0); tick();
    sys_rd_sel = 2; swr(2, 0); tick();
    exc_num = 0; swr(7, 1); tick();
    sys_rd_sel = 1; swr(1, 32'h1FF); tick();
    sys_rd_sel = 3; tick();
    tag = "R9"; sys_rd_sel = 0; swr(0, 32'h07FF_FFFF); tick();
    tick();
    sys_rd_sel = 6; tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule